// File: doc/BRIEF.md
# Interrupt Status and Mask Register Pair

This block holds the host-visible status word of a rendering engine together with a write-only mask. The status word combines several kinds of field. Some bits mirror engine state and are read-only. Some bits latch hardware events and clear when the word is read. Some are host-writable: an interrupt enable per event source, a message byte, a halt request and a few general flags. The mask decides which of the writable groups a host write may change. It also decides which sources may drive the single interrupt line.

Software first writes the mask to open the fields it wants. It then sets enable bits and polls or waits on the interrupt. Reading the status word returns the latched events and discards them in the same access. Event sources are 8 level inputs; each rising edge is one event.

Top module: `rnd_irq_status`

## Requirements
- R1: After reset the mask register holds all ones, the writable status bits and all pending bits are zero, and irqOut, haltReq and busRdata are 0.
- R2: Status bit 31 shows idleIn, bit 30 shows holdIn and bit 24 shows localIn; host writes to these bits have no effect.
- R3: A rising edge on eventIn[i] sets pending bit 16+i of the status word; an input held high sets it only once.
- R4: A status read (busRd with busAddr equal to STATUS_ADDR, default 0) returns the word as it was before the access and clears all pending bits, except that a rising edge in the same cycle leaves its bit set.
- R5: Host writes to the pending field, bits 23 to 16, have no effect.
- R6: Bits 15 to 8 (enable i at bit 8+i) are always writable and read back as written.
- R7: The message field, bits 7 to 0, is written by a status write only while mask bit 23 is 0.
- R8: Status bits 29 to 25 are written only while mask bit 22 is 0; bit 29 additionally requires mask bit 20 to be 0.
- R9: haltReq equals status bit 29 and changes only on a status write.
- R10: irqOut is 1 while some pending bit i is set with enable bit 8+i at 1 and mask bit 24+i at 0.
- R11: irqOut is also 1 while the message field is nonzero and mask bit 23 is 0.
- R12: The mask (busAddr equal to MASK_ADDR, default 1) is write-only; reading it or any unmapped address returns zero and leaves the pending bits unchanged.
- R13: Read data appears on busRdata in the cycle after busRd is sampled and is zero in every cycle that does not follow a status read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | AW (4) | Register address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| eventIn | input | 8 | Hardware event levels, one per source |
| idleIn | input | 1 | Engine idle flag |
| holdIn | input | 1 | Engine hold flag |
| localIn | input | 1 | Processor-role flag |
| irqOut | output | 1 | Interrupt request |
| haltReq | output | 1 | Halt request to the engine |

## Verification
On every cycle the assertions check the following: each edge leaves its pending bit set, and a pending bit never appears without an edge. A status read with no coincident edge empties the pending field. The message byte stays put while its mask bit is set, and the halt output moves only on a status write. Read data is zero after any cycle without a status read. Only the bench scenarios can show the actual read values under each mask setting. They also show a read and an event in the same cycle, the source-by-source interrupt gating, and a mask read that must leave the pending bits alone.

// File: rtl/rnd_irq_pkg.sv
`timescale 1ns/1ps
package rnd_irq_pkg;
  localparam int DW     = 32;
  localparam int NSRC   = 8;
  localparam int NHI    = 5;   // writable bits 29..25
  localparam int BHALT  = 29;
  localparam int MSRC   = 24;  // mask bits 31..24 gate source interrupts
  localparam int MMSG   = 23;
  localparam int MHIGRP = 22;
  localparam int MHALT  = 20;

  typedef struct packed {
    logic statusWr;
    logic statusRd;
    logic maskWr;
  } regStrb_t;
endpackage

// File: rtl/rnd_irq_ctrl.sv
`timescale 1ns/1ps
module rnd_irq_ctrl
  import rnd_irq_pkg::*;
#(
  parameter int AW          = 4,
  parameter int STATUS_ADDR = 0,
  parameter int MASK_ADDR   = 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [AW-1:0]   busAddr,
  input  logic            busWr,
  input  logic            busRd,
  input  logic [NSRC-1:0] eventIn,
  output regStrb_t        strb,
  output logic [NSRC-1:0] evRise
);
  localparam logic [AW-1:0] ST_A = AW'(STATUS_ADDR);
  localparam logic [AW-1:0] MK_A = AW'(MASK_ADDR);

  logic [NSRC-1:0] evPrev;

  always_ff @(posedge clk) begin
    if (!rstN) evPrev <= '0;
    else       evPrev <= eventIn;
  end

  assign evRise = eventIn & ~evPrev;

  always_comb begin
    strb.statusWr = busWr && (busAddr == ST_A);
    strb.statusRd = busRd && (busAddr == ST_A);
    strb.maskWr   = busWr && (busAddr == MK_A);
  end

  // R3: an edge strobe is only seen when the input was low one cycle earlier
  a_r3_edge_from_low: assert property (@(posedge clk) disable iff (!rstN)
    (|evRise) |-> ((evRise & $past(eventIn)) == '0));
endmodule

// File: rtl/rnd_irq_dp.sv
`timescale 1ns/1ps
module rnd_irq_dp
  import rnd_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  regStrb_t        strb,
  input  logic [NSRC-1:0] evRise,
  input  logic [DW-1:0]   busWdata,
  input  logic            idleIn,
  input  logic            holdIn,
  input  logic            localIn,
  output logic [DW-1:0]   busRdata,
  output logic            irqOut,
  output logic            haltReq
);
  logic [NSRC-1:0] pendQ, ctrlQ, msgQ;
  logic [NHI-1:0]  hiQ;
  logic [DW-1:0]   maskQ;
  logic [DW-1:0]   rdataQ;
  logic [DW-1:0]   statusWord;
  logic            unusedBits;

  assign statusWord = {idleIn, holdIn, hiQ, localIn, pendQ, ctrlQ, msgQ};
  assign unusedBits = ^{maskQ[21], maskQ[19:0], busWdata[23:16]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ  <= '0;
      ctrlQ  <= '0;
      msgQ   <= '0;
      hiQ    <= '0;
      maskQ  <= '1;
      rdataQ <= '0;
    end else begin
      pendQ  <= (strb.statusRd ? '0 : pendQ) | evRise;
      rdataQ <= strb.statusRd ? statusWord : '0;
      if (strb.maskWr) maskQ <= busWdata;
      if (strb.statusWr) begin
        ctrlQ <= busWdata[15:8];
        if (!maskQ[MMSG]) msgQ <= busWdata[7:0];
        if (!maskQ[MHIGRP]) begin
          hiQ[NHI-2:0] <= busWdata[BHALT-1:BHALT-NHI+1];
          if (!maskQ[MHALT]) hiQ[NHI-1] <= busWdata[BHALT];
        end
      end
    end
  end

  assign busRdata = rdataQ;
  assign haltReq  = hiQ[NHI-1];
  assign irqOut   = (|(pendQ & ctrlQ & ~maskQ[MSRC +: NSRC])) ||
                    ((|msgQ) && !maskQ[MMSG]);

  // R3: every edge leaves its pending bit set
  a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rstN)
    (|evRise) |=> ((pendQ & $past(evRise)) == $past(evRise)));
  // R4: a status read without a coincident edge empties the pending field
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statusRd && evRise == '0) |=> (pendQ == '0));
  // R5: no pending bit appears without an edge
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (evRise == '0) |=> ((pendQ & ~$past(pendQ)) == '0));
  // R7: message byte frozen while its mask bit is set
  a_r7_msg_locked: assert property (@(posedge clk) disable iff (!rstN)
    maskQ[MMSG] |=> $stable(msgQ));
  // R9: halt output moves only on a status write
  a_r9_halt_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.statusWr |=> $stable(haltReq));
  // R13: read data is zero after any cycle without a status read
  a_r13_rdata_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strb.statusRd |=> (busRdata == '0));
  // R10: interrupt without message needs some pending source
  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && msgQ == '0) |-> (|pendQ));
endmodule

// File: rtl/rnd_irq_status.sv
`timescale 1ns/1ps
module rnd_irq_status
  import rnd_irq_pkg::*;
#(
  parameter int AW          = 4,
  parameter int STATUS_ADDR = 0,
  parameter int MASK_ADDR   = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWr,
  input  logic          busRd,
  input  logic [31:0]   busWdata,
  output logic [31:0]   busRdata,
  input  logic [7:0]    eventIn,
  input  logic          idleIn,
  input  logic          holdIn,
  input  logic          localIn,
  output logic          irqOut,
  output logic          haltReq
);
  regStrb_t        strb;
  logic [NSRC-1:0] evRise;

  rnd_irq_ctrl #(
    .AW(AW), .STATUS_ADDR(STATUS_ADDR), .MASK_ADDR(MASK_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .eventIn(eventIn), .strb(strb), .evRise(evRise)
  );

  rnd_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .evRise(evRise),
    .busWdata(busWdata), .idleIn(idleIn), .holdIn(holdIn),
    .localIn(localIn), .busRdata(busRdata), .irqOut(irqOut),
    .haltReq(haltReq)
  );
endmodule

// File: tb/sim_rnd_irq_status.sv
`timescale 1ns/1ps
module sim_rnd_irq_status;
  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  busAddr;
  logic        busWr, busRd;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic [7:0]  eventIn;
  logic        idleIn, holdIn, localIn;
  logic        irqOut, haltReq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rnd_irq_status u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .eventIn(eventIn),
    .idleIn(idleIn), .holdIn(holdIn), .localIn(localIn),
    .irqOut(irqOut), .haltReq(haltReq)
  );

  // entry: {isRead, addr, data, expected, requirement number}
  localparam int NV = 21;
  localparam logic [72:0] VEC [0:NV-1] = '{
    {1'b0, 4'h0, 32'hFFFF_FFFF, 32'h0, 4'd6},
    {1'b1, 4'h0, 32'h0, 32'h8100_FF00, 4'd1},  // R1 mask all ones: only R6 field moved
    {1'b0, 4'h1, 32'h0000_0000, 32'h0, 4'd12},
    {1'b1, 4'h1, 32'h0, 32'h0000_0000, 4'd12}, // R12 mask reads zero
    {1'b0, 4'h0, 32'h5A5A_5AA5, 32'h0, 4'd8},
    {1'b1, 4'h0, 32'h0, 32'h9B00_5AA5, 4'd5},  // R5 R2 R8
    {1'b0, 4'h0, 32'h2000_0000, 32'h0, 4'd8},
    {1'b1, 4'h0, 32'h0, 32'hA100_0000, 4'd8},
    {1'b0, 4'h1, 32'h0010_0000, 32'h0, 4'd8},
    {1'b0, 4'h0, 32'h1E00_00FF, 32'h0, 4'd8},
    {1'b1, 4'h0, 32'h0, 32'hBF00_00FF, 4'd8},  // R8 bit 29 held by mask bit 20
    {1'b0, 4'h1, 32'h0040_0000, 32'h0, 4'd8},
    {1'b0, 4'h0, 32'h0000_3C11, 32'h0, 4'd8},
    {1'b1, 4'h0, 32'h0, 32'hBF00_3C11, 4'd8},  // R8 group held by mask bit 22
    {1'b0, 4'h1, 32'h0080_0000, 32'h0, 4'd7},
    {1'b0, 4'h0, 32'h0000_0077, 32'h0, 4'd7},
    {1'b1, 4'h0, 32'h0, 32'h8100_0011, 4'd7},  // R7 message held by mask bit 23
    {1'b0, 4'h1, 32'h0000_0000, 32'h0, 4'd12},
    {1'b1, 4'h5, 32'h0, 32'h0000_0000, 4'd12}, // R12 unmapped read
    {1'b0, 4'h0, 32'h0000_0000, 32'h0, 4'd6},
    {1'b1, 4'h0, 32'h0, 32'h8100_0000, 4'd6}   // R6
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busOp(input logic wr, input logic rd, input logic [3:0] a,
                       input logic [31:0] d);
    @(negedge clk);
    busWr = wr; busRd = rd; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0; busWdata = '0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; busAddr = '0; busWr = 1'b0; busRd = 1'b0; busWdata = '0;
    eventIn = '0; idleIn = 1'b1; holdIn = 1'b0; localIn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 irqOut", {31'b0, irqOut}, 32'h0);
    chk("R1 haltReq", {31'b0, haltReq}, 32'h0);
    chk("R1 busRdata", busRdata, 32'h0);
    busOp(1'b0, 1'b1, 4'h0, 32'h0);
    chk("R1 status", busRdata, 32'h8100_0000);

    for (int i = 0; i < NV; i++) begin
      busOp(!VEC[i][72], VEC[i][72], VEC[i][71:68], VEC[i][67:36]);
      if (VEC[i][72]) begin
        checks++;
        if (busRdata !== VEC[i][35:4]) begin
          errors++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h",
                   VEC[i][3:0], i, busRdata, VEC[i][35:4]);
        end
      end
    end

    // R10 R3: edge on source 0 with its enable set
    busOp(1'b1, 1'b0, 4'h0, 32'h0000_0100);
    @(negedge clk); eventIn = 8'h01;
    @(negedge clk);
    chk("R10 irq from source 0", {31'b0, irqOut}, 32'h1);
    busOp(1'b0, 1'b1, 4'h0, 32'h0);
    chk("R4 read returns pending", busRdata, 32'h8101_0100);
    chk("R4 irq after clear", {31'b0, irqOut}, 32'h0);
    busOp(1'b0, 1'b1, 4'h0, 32'h0);
    chk("R3 held level no re-set", busRdata, 32'h8100_0100);

    // R10: source 0 masked by mask bit 24
    busOp(1'b1, 1'b0, 4'h1, 32'h0100_0000);
    @(negedge clk); eventIn = 8'h00;
    @(negedge clk); eventIn = 8'h01;
    @(negedge clk);
    chk("R10 masked source", {31'b0, irqOut}, 32'h0);
    busOp(1'b0, 1'b1, 4'h0, 32'h0);
    chk("R10 pending still latched", busRdata, 32'h8101_0100);

    // R4: edge coincident with read
    @(negedge clk);
    eventIn = 8'h03; busRd = 1'b1; busAddr = 4'h0;
    @(negedge clk);
    busRd = 1'b0;
    chk("R4 coincident read value", busRdata, 32'h8100_0100);
    busOp(1'b0, 1'b1, 4'h0, 32'h0);
    chk("R4 coincident edge kept", busRdata, 32'h8102_0100);

    // R12: mask read leaves pending alone
    @(negedge clk); eventIn = 8'h07;
    busOp(1'b0, 1'b1, 4'h1, 32'h0);
    chk("R12 mask read zero", busRdata, 32'h0);
    busOp(1'b0, 1'b1, 4'h0, 32'h0);
    chk("R12 pending kept", busRdata, 32'h8104_0100);

    // R11: message interrupt
    busOp(1'b1, 1'b0, 4'h1, 32'h0);
    busOp(1'b1, 1'b0, 4'h0, 32'h0000_0001);
    chk("R11 message irq", {31'b0, irqOut}, 32'h1);
    busOp(1'b1, 1'b0, 4'h1, 32'h0080_0000);
    chk("R11 message masked", {31'b0, irqOut}, 32'h0);
    busOp(1'b1, 1'b0, 4'h1, 32'h0);

    // R9: halt request
    busOp(1'b1, 1'b0, 4'h0, 32'h2000_0000);
    chk("R9 halt set", {31'b0, haltReq}, 32'h1);
    busOp(1'b1, 1'b0, 4'h0, 32'h0);
    chk("R9 halt clear", {31'b0, haltReq}, 32'h0);

    // R2: read-only inputs followed
    @(negedge clk); idleIn = 1'b0; holdIn = 1'b1; localIn = 1'b0;
    busOp(1'b0, 1'b1, 4'h0, 32'h0);
    chk("R2 read-only bits", busRdata, 32'h4000_0000);
    @(negedge clk);
    chk("R13 rdata returns to zero", busRdata, 32'h0);

    done = 1'b1;
    finishRun();
  end
endmodule